// File: doc/BRIEF.md
# Interrupt Flag Register with Set and Clear Aliases

This block holds the interrupt state of a bus controller in one 32-bit register. The low byte has eight sticky event flags. The byte above has one enable per flag. A single self-clearing command bit releases the controller's master engine after it has halted on a missing acknowledge. Hardware event pulses latch into the flags. The single interrupt line is raised whenever a latched flag has its enable set.

Software reaches the register through three word addresses on a simple register bus. The plain address overwrites all writable bits. The set alias ORs in the ones it is given. The clear alias removes the ones it is given. Because of this, handlers can acknowledge single flags or change single enables without a read-modify-write. All three addresses read back the same current value.

Top module: `irqf_regs`

## Requirements
- R1: After reset the register reads 0, `irq_o` is low and `nak_release_o` is low.
- R2: A write to offset 0 loads bits 7:0 (flags) and bits 15:8 (enables) from the write data in the following cycle. Bits 16..27 and 29..31 always read 0.
- R3: A write to offset 4 sets every flag or enable bit whose write data bit is 1 and leaves the others unchanged.
- R4: A write to offset 8 clears every flag or enable bit whose write data bit is 1 and leaves the others unchanged.
- R5: A read at offsets 0, 4 or 8 returns the current register value. A read at any other offset returns 0, and a write there changes nothing.
- R6: A pulse on `evt_i[k]` sets flag k one cycle later. The flag then stays set until software clears it. The flag order, bit 0 upward, is:
  - slave addressed
  - slave stop
  - arbitration lost
  - early termination
  - oversize transfer
  - no acknowledge
  - engine done
  - bus free
- R7: An event on flag k in the same cycle as a write or a clear that would drop flag k leaves flag k set.
- R8: The oversize-transfer event (`evt_i[4]`) is ignored while `slave_mode_i` is low.
- R9: `irq_o` is high exactly when some flag k in bits 7:0 and its enable at bit k+8 are both set.
- R10: Writing 1 to bit 28 through offset 0 or offset 4 makes bit 28 read 1 and `nak_release_o` go high for exactly one cycle, after which both return to 0 by themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when no read hits |
| evt_i | input | 8 | Hardware event pulses, one per flag |
| slave_mode_i | input | 1 | High while the controller operates as a slave |
| irq_o | output | 1 | OR of enabled flags |
| nak_release_o | output | 1 | One-cycle pulse that releases the halted master engine |

## Verification
The assertions assume that a bus access lasts one cycle and that `evt_i` and `slave_mode_i` are synchronous to `clk_i`. The properties on stickiness and priority also rely on a write's data being stable in the cycle the write is decoded. The stimulus changes inputs only on falling edges and holds each access for exactly one cycle. It raises events either alone or in the same cycle as a deliberately conflicting write or clear, so every priority case is exercised under those assumptions.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_FLAGS  = 8;
  localparam int ENA_OFS    = 8;
  localparam int FIELD_W    = ENA_OFS + NUM_FLAGS;
  localparam int NAK_BIT    = 28;
  localparam int FLAG_OVSZ  = 4;
  localparam int OFF_BASE   = 0;
  localparam int OFF_SET    = 4;
  localparam int OFF_CLR    = 8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLR   = 2'd3
  } reg_op_e;
endpackage

// File: rtl/irqf_alias_dec.sv
module irqf_alias_dec
  import irqf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_op_e           op_o,
  output logic              rd_hit_o
);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(OFF_BASE);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);

  logic hit;

  always_comb begin
    hit  = (addr_i == A_BASE) || (addr_i == A_SET) || (addr_i == A_CLR);
    op_o = OP_NONE;
    if (req_i && we_i) begin
      if (addr_i == A_BASE)     op_o = OP_WRITE;
      else if (addr_i == A_SET) op_o = OP_SET;
      else if (addr_i == A_CLR) op_o = OP_CLR;
    end
    rd_hit_o = req_i && !we_i && hit;
  end
endmodule

// File: rtl/irqf_bit_cell.sv
module irqf_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  input  logic hw_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (wr_i)              q_d = d_i;
    else if (set_i && d_i) q_d = 1'b1;
    else if (clr_i && d_i) q_d = 1'b0;
    // hardware event wins over any software change
    if (hw_i)              q_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !wr_i && !(clr_i && d_i)) |=> q_o);

  assert_event_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_i |=> q_o);

  assert_set_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && d_i) |=> q_o);

  assert_clr_alias_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && d_i && !hw_i) |=> !q_o);
endmodule

// File: rtl/irqf_irq_or.sv
module irqf_irq_or #(
  parameter int N = 8
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] ena_i,
  output logic         irq_o
);
  logic [N-1:0] act;

  for (genvar k = 0; k < N; k++) begin : g_act
    assign act[k] = flags_i[k] & ena_i[k];
  end

  assign irq_o = |act;
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
  import irqf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic              slave_mode_i,
  output logic              irq_o,
  output logic              nak_release_o
);
  reg_op_e op;
  logic    rd_hit;
  logic [NUM_FLAGS-1:0] evt_eff;
  logic [FIELD_W-1:0]   hw_vec;
  logic [FIELD_W-1:0]   bits_q;
  logic                 nak_q;
  logic [REG_W-1:0]     reg_val;
  logic                 unused_wdata;

  assign unused_wdata = ^{wdata_i[REG_W-1:NAK_BIT+1], wdata_i[NAK_BIT-1:FIELD_W]};

  irqf_alias_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .op_o     (op),
    .rd_hit_o (rd_hit)
  );

  // oversize event only counts in slave operation
  always_comb begin
    evt_eff = evt_i;
    if (!slave_mode_i) evt_eff[FLAG_OVSZ] = 1'b0;
  end

  assign hw_vec = {{(FIELD_W-NUM_FLAGS){1'b0}}, evt_eff};

  for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
    irqf_bit_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (op == OP_WRITE),
      .set_i  (op == OP_SET),
      .clr_i  (op == OP_CLR),
      .d_i    (wdata_i[i]),
      .hw_i   (hw_vec[i]),
      .q_o    (bits_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nak_q <= 1'b0;
    else         nak_q <= ((op == OP_WRITE) || (op == OP_SET)) && wdata_i[NAK_BIT];
  end

  always_comb begin
    reg_val                = '0;
    reg_val[FIELD_W-1:0]   = bits_q;
    reg_val[NAK_BIT]       = nak_q;
  end

  assign rdata_o       = rd_hit ? reg_val : '0;
  assign nak_release_o = nak_q;

  irqf_irq_or #(.N(NUM_FLAGS)) u_irq (
    .flags_i (bits_q[NUM_FLAGS-1:0]),
    .ena_i   (bits_q[ENA_OFS +: NUM_FLAGS]),
    .irq_o   (irq_o)
  );

  assert_nak_self_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nak_q && !(req_i && we_i && wdata_i[NAK_BIT])) |=> !nak_release_o);

  assert_unmapped_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (op == OP_NONE) && (evt_eff == '0)) |=> $stable(bits_q));

  assert_ovsz_master_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && evt_i[FLAG_OVSZ] && !bits_q[FLAG_OVSZ] && !(req_i && we_i)) |=> !bits_q[FLAG_OVSZ]);

  assert_no_read_when_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> (rdata_o == '0));
endmodule

// File: tb/irqf_regs_tb_top.sv
`timescale 1ns/1ps
module irqf_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0;
  logic        slave = 1'b1;
  logic        irq;
  logic        nak;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m;

  always #2.5 clk = ~clk;

  irqf_regs #(.ADDR_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .slave_mode_i(slave),
    .irq_o(irq), .nak_release_o(nak)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_ev(input logic [3:0] a, input logic [31:0] d, input logic [7:0] ev);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; evt = ev;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_ev(a, d, 8'h00);
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk);
    evt = ev;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    chk(rdata, exp, tag);
    req = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    chk({31'b0, irq}, {31'b0, |(m[7:0] & m[15:8])}, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, 32'h0, "R1 reset value");
    chk({31'b0, irq}, 32'h0, "R1 irq");
    chk({31'b0, nak}, 32'h0, "R1 nak");

    // R2 / R9 sweep of enables against flag patterns, junk in unused bits
    for (int e = 0; e < 256; e++) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] f;
        f = 8'((j * 17) ^ (e >> 1));
        wr(4'd0, 32'hE0FF0000 | {16'h0, e[7:0], f});
        m = {e[7:0], f};
        rd(4'd0, {16'h0, m}, "R2 base write");
        chk_irq("R9 irq");
      end
    end

    // R3 / R4 set and clear aliases
    for (int i = 0; i < 256; i++) begin
      logic [15:0] a, p, q;
      a = 16'(i * 73 + 5);
      p = 16'(i * 151 + 29);
      q = 16'(i * 97 + 3);
      wr(4'd0, {16'h0, a});
      wr(4'd4, {16'h0, p});
      m = a | p;
      rd(4'd4, {16'h0, m}, "R3 set alias");
      chk_irq("R9 irq after set");
      wr(4'd8, {16'h0, q});
      m = m & ~q;
      rd(4'd8, {16'h0, m}, "R4 clear alias");
      rd(4'd0, {16'h0, m}, "R5 alias read agree");
      chk_irq("R9 irq after clear");
    end

    // R5 address map
    wr(4'd0, 32'h0000A55A);
    m = 16'hA55A;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), (a == 0 || a == 4 || a == 8) ? {16'h0, m} : 32'h0, "R5 read map");
    end
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        wr(4'(a), 32'hFFFFFFFF);
        rd(4'd0, {16'h0, m}, "R5 unmapped write ignored");
        chk({31'b0, nak}, 32'h0, "R5 unmapped nak");
      end
    end

    // R6 events latch and stick
    wr(4'd0, 32'h0);
    m = 16'h0;
    slave = 1'b1;
    for (int k = 0; k < 8; k++) begin
      pulse(8'(1 << k));
      m[k] = 1'b1;
      rd(4'd0, {16'h0, m}, "R6 event latch");
      repeat (3) @(negedge clk);
      rd(4'd0, {16'h0, m}, "R6 flag sticky");
    end

    // R8 oversize ignored in master mode
    wr(4'd8, 32'h0000FFFF);
    m = 16'h0;
    slave = 1'b0;
    pulse(8'hFF);
    m = 16'h00EF;
    rd(4'd0, {16'h0, m}, "R8 oversize masked");
    pulse(8'h10);
    rd(4'd0, {16'h0, m}, "R8 oversize alone masked");
    slave = 1'b1;
    pulse(8'h10);
    m = 16'h00FF;
    rd(4'd0, {16'h0, m}, "R8 oversize in slave mode");

    // R7 event beats clear and overwrite in the same cycle
    for (int k = 0; k < 8; k++) begin
      wr(4'd0, 32'h0000FFFF);
      wr_ev(4'd8, 32'h0000FFFF, 8'(1 << k));
      m = 16'(1 << k);
      rd(4'd0, {16'h0, m}, "R7 event vs clear");
      chk({31'b0, irq}, 32'h0, "R7 irq enables cleared");
      wr_ev(4'd0, 32'h0000FF00, 8'(1 << k));
      m = 16'hFF00 | 16'(1 << k);
      rd(4'd0, {16'h0, m}, "R7 event vs base write");
      chk_irq("R9 irq after event");
    end

    // R10 clear-NAK self clearing
    wr(4'd0, 32'h10000000);
    m = 16'h0;
    rd(4'd0, 32'h10000000, "R10 nak read via base");
    chk({31'b0, nak}, 32'h1, "R10 nak pulse");
    @(negedge clk);
    rd(4'd0, 32'h0, "R10 nak cleared");
    chk({31'b0, nak}, 32'h0, "R10 nak low");
    wr(4'd0, 32'h00000303);
    m = 16'h0303;
    wr(4'd4, 32'h10000000);
    rd(4'd4, 32'h10000303, "R10 nak via set alias");
    chk({31'b0, nak}, 32'h1, "R10 nak pulse set alias");
    @(negedge clk);
    rd(4'd0, {16'h0, m}, "R10 nak gone, flags kept");
    wr(4'd8, 32'h10000000);
    rd(4'd0, {16'h0, m}, "R10 clear alias no pulse");
    chk({31'b0, nak}, 32'h0, "R10 clear alias nak low");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule